// File: doc/BRIEF.md
# Split-Burst Read Engine

This block takes simple read requests and turns them into AXI4 read-address bursts. A request carries a consumer tag, a start byte address, a word count minus one, and a byte remainder for the last word. The engine collects the read-data beats that come back and hands them to a consumer as one stream packet per request. The packet carries keep, last and the tag of the request it belongs to.

When a request needs more words than one AXI burst can carry, the engine issues it as several consecutive bursts. All of those bursts use one fixed AXI ID, so the slave returns them in order. The consumer still sees one packet, and last is set only on the final word of the request. For each issued burst, a small in-order queue records the consumer tag, the remainder, and whether that burst closes the packet. When the queue is full, address issue stops. The read-data channel is not accepted while nothing is outstanding.

A sticky error flag goes high when any read response is not OKAY. It stays high until reset. Data keeps flowing as normal.

Top module: `rd_burst_pump`

## Requirements
- R1: After reset, reqReady is 1 and arValid, outValid, rReady and errorRead are all 0.
- R2: A request with reqLen below BURST_MAX (256) is issued as exactly one burst with arAddr equal to reqAddr and arLen equal to reqLen.
- R3: A request with reqLen of 256 or more is issued as consecutive bursts. Every burst except the last has arLen 255. Each burst address is 2048 bytes (256 words of 8 bytes) above the previous one. The final burst has arLen equal to reqLen mod 256.
- R4: Every burst has arId 0, arSize 3 (8 bytes), arBurst 2'b01 (incrementing), arCache 4'b0011, arProt 0 and arQos 0.
- R5: Each request produces one output packet of reqLen+1 words. The words arrive in address order with outData equal to rData and outId equal to reqId. outLast is 1 only on the final word of the request, including when the request was split.
- R6: On the final word of a packet, outKeep has its lowest reqRem bits set, and reqRem 0 means 8'hFF. On every other word, outKeep is 8'hFF.
- R7: When no burst is outstanding, rReady and outValid stay 0 even if rValid is 1.
- R8: At most OUTSTANDING (16) bursts are outstanding at once. When that many are waiting for data, arValid stays 0.
- R9: errorRead becomes 1 after any accepted read beat with rResp not 2'b00, and it stays 1 until reset. The data of that beat and of later beats is still delivered.
- R10: While arValid is 1 and arReady is 0, arValid stays 1 and arAddr and arLen hold their values.
- R11: reqReady stays 0 from the acceptance of a request until its last burst has been issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Request accepted when high with reqValid |
| reqId | input | 4 | Consumer tag returned as outId |
| reqAddr | input | 32 | Start byte address (word aligned) |
| reqLen | input | 9 | Word count minus one |
| reqRem | input | 3 | Valid bytes in last word, 0 = all 8 |
| arValid | output | 1 | Read-address valid |
| arReady | input | 1 | Read-address ready |
| arId | output | 4 | Fixed AXI ID |
| arAddr | output | 32 | Burst start address |
| arLen | output | 8 | Burst beats minus one |
| arSize | output | 3 | Beat size code |
| arBurst | output | 2 | Burst type |
| arCache | output | 4 | Cache attribute |
| arProt | output | 3 | Protection attribute |
| arQos | output | 4 | QoS attribute |
| rValid | input | 1 | Read-data valid |
| rReady | output | 1 | Read-data ready |
| rData | input | 64 | Read data |
| rResp | input | 2 | Read response |
| rLast | input | 1 | Last beat of a burst |
| outValid | output | 1 | Output word valid |
| outReady | input | 1 | Consumer ready |
| outData | output | 64 | Output word |
| outKeep | output | 8 | Byte enables of the word |
| outLast | output | 1 | Final word of a request |
| outId | output | 4 | Tag of the owning request |
| errorRead | output | 1 | Sticky read-error flag |

## Verification
The bench builds the engine with its defaults: BURST_MAX of 256, a 9-bit length and a 16-entry end queue. With these values, the largest request is exactly two bursts, and 257 words gives a one-beat tail burst. Seventeen single-word requests are enough to fill the end queue while the slave withholds data, which puts the address-stall boundary and its recovery within reach. A behavioural slave and consumer insert random stalls, so packet merging is checked across bursts whose data arrives with gaps.

// File: rtl/rd_burst_pkg.sv
package rd_burst_pkg;
  parameter int unsigned DATA_W = 64;
  parameter int unsigned ID_W   = 4;
  localparam int unsigned BYTES = DATA_W / 8;
  localparam int unsigned REM_W = $clog2(BYTES);

  // Per-burst information kept until that burst's last beat returns
  typedef struct packed {
    logic [ID_W-1:0]  id;
    logic [REM_W-1:0] rem;
    logic             propLast;
  } endInfo_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic     push;
    endInfo_t info;
  } endStrobe_t;
endpackage

// File: rtl/rd_burst_fifo.sv
module rd_burst_fifo
  import rd_burst_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     pushEn,
  input  endInfo_t pushData,
  input  logic     popEn,
  output logic     full,
  output logic     empty,
  output endInfo_t head
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  endInfo_t        mem [DEPTH];
  logic [PW-1:0]   wrPtr, rdPtr;
  logic [CW-1:0]   count;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign head  = mem[rdPtr];

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (pushEn && !full) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (pushEn && !full) wrPtr <= nextPtr(wrPtr);
      if (popEn && !empty) rdPtr <= nextPtr(rdPtr);
      case ({pushEn && !full, popEn && !empty})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/rd_burst_ctrl.sv
module rd_burst_ctrl
  import rd_burst_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned LEN_W     = 9,
  parameter int unsigned BURST_MAX = 256
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      reqValid,
  output logic                      reqReady,
  input  logic [ID_W-1:0]           reqId,
  input  logic [ADDR_W-1:0]         reqAddr,
  input  logic [LEN_W-1:0]          reqLen,
  input  logic [REM_W-1:0]          reqRem,
  input  logic                      fifoFull,
  output logic                      arValid,
  input  logic                      arReady,
  output logic [ADDR_W-1:0]         arAddr,
  output logic [$clog2(BURST_MAX)-1:0] arLen,
  output endStrobe_t                strobe
);
  localparam int unsigned ALEN_W = $clog2(BURST_MAX);
  localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(BURST_MAX * BYTES);

  logic              busy;
  logic [ADDR_W-1:0] curAddr;
  logic [LEN_W-1:0]  remain;
  logic [ID_W-1:0]   curId;
  logic [REM_W-1:0]  curRem;
  logic              lastBurst;
  logic              arFire;

  assign lastBurst = (remain < LEN_W'(BURST_MAX));
  assign reqReady  = !busy;
  assign arValid   = busy && !fifoFull;
  assign arFire    = arValid && arReady;
  assign arAddr    = curAddr;
  assign arLen     = lastBurst ? remain[ALEN_W-1:0] : ALEN_W'(BURST_MAX - 1);

  always_comb begin
    strobe.push          = arFire;
    strobe.info.id       = curId;
    strobe.info.rem      = curRem;
    strobe.info.propLast = lastBurst;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      curAddr <= '0;
      remain  <= '0;
      curId   <= '0;
      curRem  <= '0;
    end else if (!busy) begin
      if (reqValid) begin
        busy    <= 1'b1;
        curAddr <= reqAddr;
        remain  <= reqLen;
        curId   <= reqId;
        curRem  <= reqRem;
      end
    end else if (arFire) begin
      if (lastBurst) begin
        busy <= 1'b0;
      end else begin
        curAddr <= curAddr + ADDR_STEP;
        remain  <= remain - LEN_W'(BURST_MAX);
      end
    end
  end
endmodule

// File: rtl/rd_burst_data.sv
module rd_burst_data
  import rd_burst_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  endStrobe_t        strobe,
  output logic              fifoFull,
  input  logic              rValid,
  output logic              rReady,
  input  logic [DATA_W-1:0] rData,
  input  logic [1:0]        rResp,
  input  logic              rLast,
  output logic              outValid,
  input  logic              outReady,
  output logic [DATA_W-1:0] outData,
  output logic [BYTES-1:0]  outKeep,
  output logic              outLast,
  output logic [ID_W-1:0]   outId,
  output logic              errorRead
);
  endInfo_t         head;
  logic             fifoEmpty;
  logic             beatFire;
  logic [BYTES-1:0] lastKeep;

  rd_burst_fifo #(.DEPTH(DEPTH)) endQ_i (
    .clk      (clk),
    .rstN     (rstN),
    .pushEn   (strobe.push),
    .pushData (strobe.info),
    .popEn    (beatFire && rLast),
    .full     (fifoFull),
    .empty    (fifoEmpty),
    .head     (head)
  );

  for (genvar g = 0; g < BYTES; g++) begin : g_keep
    assign lastKeep[g] = (head.rem == '0) ||
                         ((REM_W + 1)'(g) < {1'b0, head.rem});
  end

  assign rReady   = outReady && !fifoEmpty;
  assign outValid = rValid && !fifoEmpty;
  assign beatFire = rValid && rReady;
  assign outData  = rData;
  assign outLast  = rLast && head.propLast;
  assign outKeep  = outLast ? lastKeep : '1;
  assign outId    = head.id;

  always_ff @(posedge clk) begin
    if (!rstN)                          errorRead <= 1'b0;
    else if (beatFire && rResp != 2'b00) errorRead <= 1'b1;
  end
endmodule

// File: rtl/rd_burst_pump.sv
module rd_burst_pump
  import rd_burst_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned LEN_W       = 9,
  parameter int unsigned BURST_MAX   = 256,
  parameter int unsigned OUTSTANDING = 16,
  parameter int unsigned AXI_ID_W    = 4,
  parameter int unsigned AXI_ID_VAL  = 0,
  parameter int unsigned CACHE_VAL   = 3,
  parameter int unsigned PROT_VAL    = 0,
  parameter int unsigned QOS_VAL     = 0
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         reqValid,
  output logic                         reqReady,
  input  logic [ID_W-1:0]              reqId,
  input  logic [ADDR_W-1:0]            reqAddr,
  input  logic [LEN_W-1:0]             reqLen,
  input  logic [REM_W-1:0]             reqRem,
  output logic                         arValid,
  input  logic                         arReady,
  output logic [AXI_ID_W-1:0]          arId,
  output logic [ADDR_W-1:0]            arAddr,
  output logic [$clog2(BURST_MAX)-1:0] arLen,
  output logic [2:0]                   arSize,
  output logic [1:0]                   arBurst,
  output logic [3:0]                   arCache,
  output logic [2:0]                   arProt,
  output logic [3:0]                   arQos,
  input  logic                         rValid,
  output logic                         rReady,
  input  logic [DATA_W-1:0]            rData,
  input  logic [1:0]                   rResp,
  input  logic                         rLast,
  output logic                         outValid,
  input  logic                         outReady,
  output logic [DATA_W-1:0]            outData,
  output logic [BYTES-1:0]             outKeep,
  output logic                         outLast,
  output logic [ID_W-1:0]              outId,
  output logic                         errorRead
);
  endStrobe_t strobe;
  logic       fifoFull;

  assign arId    = AXI_ID_W'(AXI_ID_VAL);
  assign arSize  = 3'($clog2(BYTES));
  assign arBurst = 2'b01;
  assign arCache = 4'(CACHE_VAL);
  assign arProt  = 3'(PROT_VAL);
  assign arQos   = 4'(QOS_VAL);

  rd_burst_ctrl #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BURST_MAX(BURST_MAX)
  ) ctrl_i (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqId(reqId),
    .reqAddr(reqAddr), .reqLen(reqLen), .reqRem(reqRem),
    .fifoFull(fifoFull),
    .arValid(arValid), .arReady(arReady), .arAddr(arAddr), .arLen(arLen),
    .strobe(strobe)
  );

  rd_burst_data #(.DEPTH(OUTSTANDING)) data_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .fifoFull(fifoFull),
    .rValid(rValid), .rReady(rReady), .rData(rData), .rResp(rResp), .rLast(rLast),
    .outValid(outValid), .outReady(outReady), .outData(outData),
    .outKeep(outKeep), .outLast(outLast), .outId(outId),
    .errorRead(errorRead)
  );
endmodule

// File: rtl/rd_burst_chk.sv
module rd_burst_chk #(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned ALEN_W      = 8,
  parameter int unsigned AXI_ID_W    = 4,
  parameter int unsigned OUTSTANDING = 16,
  parameter int unsigned AXI_ID_VAL  = 0,
  parameter int unsigned CACHE_VAL   = 3
) (
  input logic                clk,
  input logic                rstN,
  input logic                arValid,
  input logic                arReady,
  input logic [AXI_ID_W-1:0] arId,
  input logic [ADDR_W-1:0]   arAddr,
  input logic [ALEN_W-1:0]   arLen,
  input logic [2:0]          arSize,
  input logic [1:0]          arBurst,
  input logic [3:0]          arCache,
  input logic [2:0]          arProt,
  input logic [3:0]          arQos,
  input logic                rValid,
  input logic                rReady,
  input logic                rLast,
  input logic                outValid,
  input logic                outLast,
  input logic                errorRead
);
  localparam int unsigned CW = $clog2(OUTSTANDING + 2);
  logic [CW-1:0] pendCnt;

  always_ff @(posedge clk) begin
    if (!rstN) pendCnt <= '0;
    else pendCnt <= pendCnt + CW'(arValid && arReady) - CW'(rValid && rReady && rLast);
  end

  // R7
  no_idle_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    rReady |-> pendCnt != '0);

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    pendCnt <= CW'(OUTSTANDING));

  // R10
  ar_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    arValid && !arReady |=> arValid && $stable(arAddr) && $stable(arLen));

  // R4
  ar_attr_chk: assert property (@(posedge clk) disable iff (!rstN)
    arValid |-> arId == AXI_ID_W'(AXI_ID_VAL) && arSize == 3'd3 && arBurst == 2'b01
                && arCache == 4'(CACHE_VAL) && arProt == 3'd0 && arQos == 4'd0);

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    errorRead |=> errorRead);

  // R5
  last_on_beat_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outLast |-> rLast);
endmodule

bind rd_burst_pump rd_burst_chk #(
  .ADDR_W(ADDR_W), .ALEN_W($clog2(BURST_MAX)), .AXI_ID_W(AXI_ID_W),
  .OUTSTANDING(OUTSTANDING), .AXI_ID_VAL(AXI_ID_VAL), .CACHE_VAL(CACHE_VAL)
) chk_i (
  .clk(clk), .rstN(rstN), .arValid(arValid), .arReady(arReady), .arId(arId),
  .arAddr(arAddr), .arLen(arLen), .arSize(arSize), .arBurst(arBurst),
  .arCache(arCache), .arProt(arProt), .arQos(arQos), .rValid(rValid),
  .rReady(rReady), .rLast(rLast), .outValid(outValid), .outLast(outLast),
  .errorRead(errorRead)
);

// File: tb/rd_burst_pump_tb_top.sv
module rd_burst_pump_tb_top;
  import rd_burst_pkg::*;
  localparam int CLK_P = 10;
  localparam int QTR   = 2;

  logic clk = 1'b0, rstN = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic reqValid = 1'b0, reqReady;
  logic [3:0] reqId = '0;
  logic [31:0] reqAddr = '0;
  logic [8:0] reqLen = '0;
  logic [2:0] reqRem = '0;
  logic arValid, arReady;
  logic [3:0] arId; logic [31:0] arAddr; logic [7:0] arLen;
  logic [2:0] arSize; logic [1:0] arBurst; logic [3:0] arCache; logic [2:0] arProt; logic [3:0] arQos;
  logic rValid, rReady, rLast; logic [63:0] rData; logic [1:0] rResp;
  logic outValid, outReady, outLast; logic [63:0] outData; logic [7:0] outKeep; logic [3:0] outId;
  logic errorRead;

  rd_burst_pump dut_i (.*);

  int checks = 0, errors = 0;
  bit arStall = 0, rStall = 0, rnd = 0, errInject = 0, spur = 0;

  typedef struct packed { logic [31:0] addr; logic [7:0] len; } arRec_t;
  typedef struct packed { logic last; logic [7:0] keep; logic [3:0] id; logic [63:0] data; } outRec_t;
  arRec_t arPend[$], arLog[$];
  outRec_t outQ[$];

  function automatic logic [63:0] memWord(input logic [31:0] a);
    return {a ^ 32'h5A5A_5A5A, a};
  endfunction

  function automatic logic [7:0] keepOf(input logic [2:0] r);
    return (r == 0) ? 8'hFF : (8'hFF >> (8 - r));
  endfunction

  task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural AXI read slave
  initial begin
    int beat = 0;
    bit rKeep = 0;
    arReady = 0; rValid = 0; rLast = 0; rData = '0; rResp = '0;
    forever begin
      @(negedge clk);
      arReady = !arStall && (!rnd || ($urandom % 4 != 0));
      if (spur) begin
        rValid = 1; rLast = 1; rData = '0; rResp = '0;
      end else if (arPend.size() > 0 && !rStall) begin
        rValid = rKeep ? 1'b1 : (!rnd || ($urandom % 3 != 0));
        rData  = memWord(arPend[0].addr + 32'(beat * 8));
        rLast  = (beat == int'(arPend[0].len));
        rResp  = errInject ? 2'b10 : 2'b00;
      end else begin
        rValid = 0; rLast = 0;
      end
      #(QTR);
      rKeep = rValid && !rReady && !spur;
      if (rstN && arValid && arReady) begin
        arPend.push_back({arAddr, arLen});
        arLog.push_back({arAddr, arLen});
        chk(arId == 0 && arSize == 3 && arBurst == 2'b01 && arCache == 4'd3 && arProt == 0 && arQos == 0,
            "R4 burst attributes", {arId, arSize, arBurst, arCache, arProt, arQos},
            {4'd0, 3'd3, 2'b01, 4'd3, 3'd0, 4'd0});
      end
      if (rstN && rValid && rReady && !spur) begin
        if (rLast) begin void'(arPend.pop_front()); beat = 0; end
        else beat++;
      end
    end
  end

  // consumer
  initial begin
    outReady = 0;
    forever begin
      @(negedge clk);
      outReady = !rnd || ($urandom % 4 != 0);
      #(QTR);
      if (rstN && outValid && outReady) outQ.push_back({outLast, outKeep, outId, outData});
    end
  end

  task automatic sendReq(input logic [3:0] id, input logic [31:0] a, input logic [8:0] l, input logic [2:0] r);
    @(negedge clk);
    reqValid = 1; reqId = id; reqAddr = a; reqLen = l; reqRem = r;
    forever begin
      #(QTR);
      if (reqReady) break;
      @(negedge clk);
    end
    @(negedge clk);
    reqValid = 0;
  endtask

  task automatic waitBeats(input int n);
    for (int i = 0; i < 20000 && outQ.size() < n; i++) @(negedge clk);
  endtask

  task automatic checkBursts(input logic [31:0] a, input logic [8:0] l, input string req);
    int remain = int'(l);
    logic [31:0] ea = a;
    forever begin
      arRec_t got;
      logic [7:0] el = (remain > 255) ? 8'd255 : 8'(remain);
      got = (arLog.size() > 0) ? arLog.pop_front() : '0;
      chk(got == {ea, el}, req, got, {ea, el});
      if (remain < 256) break;
      remain -= 256; ea += 32'd2048;
    end
  endtask

  task automatic checkPacket(input logic [3:0] id, input logic [31:0] a, input logic [8:0] l, input logic [2:0] r);
    for (int i = 0; i <= int'(l); i++) begin
      outRec_t got, exp;
      bit fin = (i == int'(l));
      exp = {fin, fin ? keepOf(r) : 8'hFF, id, memWord(a + 32'(i * 8))};
      got = (outQ.size() > 0) ? outQ.pop_front() : '0;
      chk(got == exp, fin ? "R5/R6 final word" : "R5/R6 word", got, exp);
    end
  endtask

  task automatic runOne(input logic [3:0] id, input logic [31:0] a, input logic [8:0] l,
                        input logic [2:0] r, input string breq);
    sendReq(id, a, l, r);
    waitBeats(int'(l) + 1);
    repeat (3) @(negedge clk);
    checkBursts(a, l, breq);
    checkPacket(id, a, l, r);
    chk(outQ.size() == 0, "R5 no extra words", 96'(outQ.size()), 0);
  endtask

  task automatic t_reset;
    @(negedge clk); #(QTR);
    chk(reqReady == 1, "R1 reqReady", 96'(reqReady), 1);
    chk({arValid, outValid, rReady, errorRead} == 0, "R1 idle outputs",
        {arValid, outValid, rReady, errorRead}, 0);
    spur = 1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #(QTR);
      chk({rReady, outValid} == 0, "R7 idle read channel blocked", {rReady, outValid}, 0);
    end
    spur = 0;
  endtask

  task automatic t_sizes;
    rnd = 0;
    runOne(4'h1, 32'h0000_1000, 9'd0, 3'd5, "R2 single word burst");
    rnd = 1;
    runOne(4'h2, 32'h0001_0000, 9'd255, 3'd0, "R2 full 256 burst");
    runOne(4'h3, 32'h0002_0000, 9'd256, 3'd3, "R3 257 split");
    runOne(4'h4, 32'h0004_0000, 9'd511, 3'd7, "R3 512 split");
    runOne(4'h5, 32'h0008_0040, 9'd9, 3'd1, "R2 short burst");
  endtask

  task automatic t_hold;
    logic [31:0] a0; logic [7:0] l0;
    rnd = 0; arStall = 1;
    sendReq(4'h6, 32'h0010_0000, 9'd300, 3'd2);
    repeat (2) @(negedge clk);
    #(QTR); a0 = arAddr; l0 = arLen;
    repeat (4) @(negedge clk);
    #(QTR);
    chk(arValid && arAddr == a0 && arLen == l0 && l0 == 8'd255, "R10 address held while stalled",
        {arValid, arAddr, arLen}, {1'b1, 32'h0010_0000, 8'd255});
    chk(reqReady == 0, "R11 no new request while splitting", 96'(reqReady), 0);
    arStall = 0;
    waitBeats(301);
    repeat (3) @(negedge clk);
    checkBursts(32'h0010_0000, 9'd300, "R3 300 split after stall");
    checkPacket(4'h6, 32'h0010_0000, 9'd300, 3'd2);
  endtask

  task automatic t_depth;
    rnd = 0; rStall = 1;
    for (int i = 0; i < 17; i++) sendReq(4'(i), 32'h0020_0000 + 32'(i * 64), 9'd0, 3'd4);
    repeat (10) @(negedge clk);
    #(QTR);
    chk(arLog.size() == 16, "R8 outstanding limit", 96'(arLog.size()), 16);
    chk(arValid == 0 && reqReady == 0, "R8 address stalls when full", {arValid, reqReady}, 0);
    rStall = 0; rnd = 1;
    waitBeats(17);
    repeat (3) @(negedge clk);
    for (int i = 0; i < 17; i++) checkBursts(32'h0020_0000 + 32'(i * 64), 9'd0, "R8 queued burst");
    for (int i = 0; i < 17; i++) checkPacket(4'(i), 32'h0020_0000 + 32'(i * 64), 9'd0, 3'd4);
  endtask

  task automatic t_error;
    rnd = 0;
    chk(errorRead == 0, "R9 clear before error", 96'(errorRead), 0);
    errInject = 1;
    sendReq(4'h9, 32'h0030_0000, 9'd1, 3'd0);
    waitBeats(2);
    errInject = 0;
    repeat (2) @(negedge clk);
    checkBursts(32'h0030_0000, 9'd1, "R9 burst");
    checkPacket(4'h9, 32'h0030_0000, 9'd1, 3'd0);
    #(QTR);
    chk(errorRead == 1, "R9 error raised", 96'(errorRead), 1);
    runOne(4'hA, 32'h0030_1000, 9'd2, 3'd6, "R9 traffic after error");
    chk(errorRead == 1, "R9 error sticky", 96'(errorRead), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1;
    t_reset;
    t_sizes;
    t_hold;
    t_depth;
    t_error;
    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule